// File: doc/BRIEF.md
# AEGIS-128 State Update Engine

This block keeps the 640-bit internal state of the AEGIS-128 authenticated cipher as five 128-bit lanes. It advances the whole state in one clock cycle. Every lane passes through a keyless AES round, and each round result is XORed into the next lane around a ring. The 128-bit message word is folded into the value that lands in lane 0. Key setup, associated-data and tag sequencing, and keystream generation belong to the surrounding controller. This block only holds the state and applies the update equations.

The controller writes a complete packed state image through the load port, gives one message word per update strobe, and reads the registered state back in the same packed layout. A load and an update in the same cycle resolve in favour of the load. The AES round logic, S-box included, sits inside the block.

Top module: `aegis_state_update`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes all zero, and `state_out` reads zero in the following cycle.
- R2: When `load_en` is high at a rising edge, the state takes `load_state` unchanged, and `state_out` shows it after that edge.
- R3: When `load_en` and `upd_en` are both high at an edge, the load wins and the update is dropped.
- R4: With `load_en` and `upd_en` both low, the state holds its value.
- R5: On an update, lane i (i = 1..4) becomes S_i XOR R(S_(i-1)). Every S in this equation is the value from before the edge.
- R6: On an update, lane 0 becomes S0 XOR msg XOR R(S4), using the pre-update S0 and S4.
- R7: R consists of ShiftRows, then SubBytes with the standard AES forward S-box (S(0x00)=0x63), then MixColumns, and has no key addition. A state that is all zero, updated with a zero message, therefore becomes 0x63 in every byte of every lane.
- R8: Packed layout: lane i occupies bits [128i+127:128i], and byte k of a lane occupies bits [8k+7:8k] of that lane. ShiftRows makes output byte k equal to input byte {0,5,10,15,4,9,14,3,8,13,2,7,12,1,6,11}[k]. A byte's MixColumns column is k/4.
- R9: Updates on consecutive cycles each apply in full, one update per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load the packed state image this edge |
| load_state | input | 640 | Packed state image to load |
| upd_en | input | 1 | Apply one state update this edge |
| msg | input | 128 | Message word folded into lane 0 |
| state_out | output | 640 | Registered state in packed layout |

## Verification
The assertions assume that `rst`, `load_en` and `upd_en` are always driven to known levels after time zero. They also assume that the data inputs carry known values in every cycle where a strobe is high. The per-lane ring assertions further take it that the previous cycle was out of reset, since their antecedents mention that cycle. The stimulus changes the inputs only on falling edges and always drives fully defined random words. It keeps reset high from time zero across the first edges, so no property ever sees unset strobes.

// File: rtl/aegis_pkg.sv
package aegis_pkg;
  localparam int LANE_W     = 128;
  localparam int LANE_BYTES = LANE_W / 8;

  typedef logic [LANE_W-1:0] lane_t;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_x2(sh);
    end
    return acc;
  endfunction
endpackage

// File: rtl/aegis_sbox.sv
module aegis_sbox
  import aegis_pkg::*;
(
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [7:0] inv;

  // inverse as din^254 by square-and-multiply; zero maps to zero
  always_comb begin
    logic [7:0] p;
    inv = 8'h01;
    p   = din;
    for (int i = 1; i < 8; i++) begin
      p   = gf_mul(p, p);
      inv = gf_mul(inv, p);
    end
  end

  // affine output map
  always_comb begin
    dout = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
         ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  end

  always_comb begin
    if (din == 8'h00) assert (dout == 8'h63)
      else $error("p_sbox_zero_r7: S(0) wrong");
  end
endmodule

// File: rtl/aegis_aes_round.sv
module aegis_aes_round
  import aegis_pkg::*;
(
  input  lane_t din,
  output lane_t dout
);
  localparam int COLS = LANE_BYTES / 4;

  logic [7:0] shifted [LANE_BYTES];
  logic [7:0] subbed  [LANE_BYTES];

  // ShiftRows gather then SubBytes, one S-box per byte
  for (genvar k = 0; k < LANE_BYTES; k++) begin : g_byte
    localparam int COL = k / 4;
    localparam int ROW = k % 4;
    localparam int SRC = 4 * ((COL + ROW) % COLS) + ROW;
    assign shifted[k] = din[8*SRC +: 8];
    aegis_sbox u_sbox (.din(shifted[k]), .dout(subbed[k]));
  end

  // MixColumns, zero round key
  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [7:0] a0, a1, a2, a3;
    assign a0 = subbed[4*c];
    assign a1 = subbed[4*c+1];
    assign a2 = subbed[4*c+2];
    assign a3 = subbed[4*c+3];
    assign dout[32*c +: 8]      = gf_x2(a0) ^ gf_x2(a1) ^ a1 ^ a2 ^ a3;
    assign dout[32*c+8 +: 8]    = a0 ^ gf_x2(a1) ^ gf_x2(a2) ^ a2 ^ a3;
    assign dout[32*c+16 +: 8]   = a0 ^ a1 ^ gf_x2(a2) ^ gf_x2(a3) ^ a3;
    assign dout[32*c+24 +: 8]   = gf_x2(a0) ^ a0 ^ a1 ^ a2 ^ gf_x2(a3);
  end

  always_comb begin
    if (din == '0) assert (dout == {LANE_BYTES{8'h63}})
      else $error("p_zero_round_r7: round of zero lane wrong");
  end
endmodule

// File: rtl/aegis_state_update.sv
module aegis_state_update
  import aegis_pkg::*;
#(
  parameter int NUM_LANES = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load_en,
  input  logic [NUM_LANES*LANE_W-1:0] load_state,
  input  logic                        upd_en,
  input  logic [LANE_W-1:0]           msg,
  output logic [NUM_LANES*LANE_W-1:0] state_out
);
  localparam int STATE_W = NUM_LANES * LANE_W;

  lane_t lane_q   [NUM_LANES];
  lane_t rnd      [NUM_LANES];
  lane_t lane_nxt [NUM_LANES];

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    aegis_aes_round u_round (.din(lane_q[i]), .dout(rnd[i]));

    if (i == 0) begin : g_head
      assign lane_nxt[i] = lane_q[i] ^ msg ^ rnd[NUM_LANES-1];
    end else begin : g_link
      assign lane_nxt[i] = lane_q[i] ^ rnd[i-1];
    end

    always_ff @(posedge clk) begin
      if (rst)          lane_q[i] <= '0;
      else if (load_en) lane_q[i] <= load_state[LANE_W*i +: LANE_W];
      else if (upd_en)  lane_q[i] <= lane_nxt[i];
    end

    assign state_out[LANE_W*i +: LANE_W] = lane_q[i];

    if (i == 0) begin : g_chk_head
      p_lane0_fold_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !load_en) |=>
          ((lane_q[0] ^ $past(lane_q[0]) ^ $past(msg)) == $past(rnd[NUM_LANES-1])))
        else $error("lane 0 fold wrong");
    end else begin : g_chk_link
      p_lane_ring_r5: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !load_en) |=> ((lane_q[i] ^ $past(lane_q[i])) == $past(rnd[i-1])))
        else $error("ring lane wrong");
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (state_out == {STATE_W{1'b0}}))
    else $error("reset did not clear");

  p_load_wins_r3: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (state_out == $past(load_state)))
    else $error("load not taken");

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !upd_en) |=> $stable(state_out))
    else $error("state moved while idle");
endmodule

// File: tb/sim_aegis_state_update.sv
module sim_aegis_state_update;
  localparam int NL = 5;
  localparam int SW = NL * 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_en = 1'b0;
  logic [SW-1:0] load_state = '0;
  logic          upd_en = 1'b0;
  logic [127:0]  msg = '0;
  logic [SW-1:0] state_out;

  int total = 0;
  int bad   = 0;
  logic [SW-1:0] exp_st;
  logic [7:0] alog [256];
  logic [7:0] lg   [256];

  always #4 clk = ~clk;

  aegis_state_update u0 (
    .clk(clk), .rst(rst), .load_en(load_en), .load_state(load_state),
    .upd_en(upd_en), .msg(msg), .state_out(state_out)
  );

  function automatic logic [7:0] xt(input logic [7:0] a);
    return (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] x);
    logic [7:0] s, o;
    s = (x == 8'h00) ? 8'h00 : alog[(255 - int'(lg[x])) % 255];
    for (int i = 0; i < 8; i++)
      o[i] = s[i] ^ s[(i+4)%8] ^ s[(i+5)%8] ^ s[(i+6)%8] ^ s[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
    return o;
  endfunction

  function automatic logic [127:0] m_round(input logic [127:0] w);
    logic [7:0] b [16];
    logic [127:0] r;
    int map [16] = '{0,5,10,15,4,9,14,3,8,13,2,7,12,1,6,11};
    for (int k = 0; k < 16; k++) b[k] = m_sbox(w[8*map[k] +: 8]);
    for (int c = 0; c < 4; c++) begin
      logic [7:0] a0, a1, a2, a3;
      a0 = b[4*c]; a1 = b[4*c+1]; a2 = b[4*c+2]; a3 = b[4*c+3];
      r[32*c +: 8]    = xt(a0) ^ (xt(a1) ^ a1) ^ a2 ^ a3;
      r[32*c+8 +: 8]  = a0 ^ xt(a1) ^ (xt(a2) ^ a2) ^ a3;
      r[32*c+16 +: 8] = a0 ^ a1 ^ xt(a2) ^ (xt(a3) ^ a3);
      r[32*c+24 +: 8] = (xt(a0) ^ a0) ^ a1 ^ a2 ^ xt(a3);
    end
    return r;
  endfunction

  function automatic logic [SW-1:0] m_update(input logic [SW-1:0] s, input logic [127:0] m);
    logic [SW-1:0] n;
    n[127:0] = s[127:0] ^ m ^ m_round(s[128*(NL-1) +: 128]);
    for (int i = 1; i < NL; i++)
      n[128*i +: 128] = s[128*i +: 128] ^ m_round(s[128*(i-1) +: 128]);
    return n;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [SW-1:0] rnd_state();
    logic [SW-1:0] v;
    for (int i = 0; i < NL; i++) v[128*i +: 128] = rnd128();
    return v;
  endfunction

  task automatic chk_all(input string tag);
    total++;
    if (state_out !== exp_st) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, state_out, exp_st);
    end
  endtask

  // lane-by-lane: lane 0 is R6, the others R5
  task automatic chk_lanes(input string ctx);
    for (int i = 0; i < NL; i++) begin
      total++;
      if (state_out[128*i +: 128] !== exp_st[128*i +: 128]) begin
        bad++;
        $display("FAIL %s %s lane %0d: act=%h exp=%h", (i == 0) ? "R6" : "R5", ctx, i,
                 state_out[128*i +: 128], exp_st[128*i +: 128]);
      end
    end
  endtask

  task automatic step(input logic ld, input logic [SW-1:0] img, input logic up, input logic [127:0] m);
    @(negedge clk);
    load_en = ld; load_state = img; upd_en = up; msg = m;
    @(posedge clk);
    if (ld)      exp_st = img;
    else if (up) exp_st = m_update(exp_st, m);
    #2;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_0a11));
    v = 8'h01;
    for (int i = 0; i < 255; i++) begin
      alog[i] = v; lg[v] = 8'(i);
      v = v ^ xt(v);
    end
    alog[255] = 8'h01; lg[0] = 8'h00;

    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    exp_st = '0;
    #1 chk_all("R1 reset");

    // R7 zero state, zero message
    step(1'b0, '0, 1'b1, '0);
    exp_st = {(SW/8){8'h63}};
    chk_all("R7 zero state update");

    // R4 idle hold
    step(1'b0, rnd_state(), 1'b0, rnd128());
    chk_all("R4 idle hold");

    // R2/R8 layout: byte j of the image equals j
    begin
      logic [SW-1:0] img;
      for (int j = 0; j < SW/8; j++) img[8*j +: 8] = 8'(j);
      step(1'b1, img, 1'b0, '0);
      chk_all("R2 load image");
      total++;
      if (state_out[128*3 + 8*5 +: 8] !== 8'd53) begin
        bad++;
        $display("FAIL R8 byte offset: act=%h exp=%h", state_out[128*3 + 8*5 +: 8], 8'd53);
      end
      step(1'b0, '0, 1'b1, '0);
      chk_lanes("R8 layout update");
    end

    // R3 load wins over update
    begin
      logic [SW-1:0] img;
      img = rnd_state();
      step(1'b1, img, 1'b1, rnd128());
      chk_all("R3 load priority");
    end

    // all-ones message on all-zero state
    step(1'b1, '0, 1'b0, '0);
    step(1'b0, '0, 1'b1, {128{1'b1}});
    chk_lanes("all-ones msg");

    // R9 back-to-back updates, then random mix
    for (int n = 0; n < 300; n++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0)      step(1'b1, rnd_state(), 1'b0, rnd128());
      else if (sel == 1) step(1'b0, rnd_state(), 1'b0, rnd128());
      else if (sel == 2) step(1'b1, rnd_state(), 1'b1, rnd128());
      else               step(1'b0, rnd_state(), 1'b1, rnd128());
      if (sel >= 3) chk_lanes("R9 random update");
      else if (sel == 1) chk_all("R4 random idle");
      else chk_all("R2 random load");
    end

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1; upd_en = 1'b1;
    @(posedge clk); #2;
    exp_st = '0;
    chk_all("R1 reset after traffic");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule